// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register File

This block models the register face of a PC-style battery clock. Software first writes an index to an index port. It then reads or writes the selected byte through a data port. Indices 0x0 to 0x9 hold the calendar and time bytes, which are loaded from parameters at reset and do not advance by themselves. Indices 0xA to 0xD are four control/status registers, called A, B, C and D. Register A carries a fixed time-base and rate setting together with an update-in-progress flag that inverts on every read. Register B holds the mode bits, including the enable for a periodic interrupt. C and D are placeholders that read as zero.

The periodic interrupt comes from a small tick state machine with three states. TM_OFF is idle. TM_ARMED counts system clock cycles. TM_EXPIRE lasts one cycle and drives the interrupt. The transitions are:
- start: TM_OFF to TM_ARMED when the enable becomes set.
- expire: TM_ARMED to TM_EXPIRE when the interval has elapsed.
- rearm: TM_EXPIRE back to TM_ARMED, with the expiry cycle counted as the first cycle of the next interval.
- stop: TM_ARMED or TM_EXPIRE to TM_OFF when the enable is cleared.

Writes the block cannot honour are refused and reported by a one-cycle error pulse. These are an out-of-range index, a disallowed register A or B value, and any write to C or D.

Top module: `rtc_cmos_regfile`

## Requirements
- R1: An index write with a value 0x00 to 0x0D selects that register. A larger value leaves the selected index unchanged, and `err` is high in the cycle after the strobe.
- R2: A data write to index 0x0 to 0x9 stores the byte in the calendar array. A data read of that index returns the stored byte on `rdata` in the cycle after the read strobe, and `rdata` holds until the next read.
- R3: After reset, register A holds 0x26 (bits 6:4 = 010 for the 32.768 kHz time base, bits 3:0 = 0110 for the 1024 Hz rate). Register B holds 0x46 (bit 6 interrupt enable, bit 2 binary data, bit 1 24-hour). `rdata`, `err` and `irq` are low.
- R4: Every read of register A inverts bit 7 (update in progress) before the value is returned, so successive reads alternate 0xA6 and 0x26 from reset.
- R5: A write to register B is accepted only when all bits other than bit 6 (interrupt enable) and bit 3 (square-wave enable) equal 0x06. Any other value sets `err` and leaves B unchanged.
- R6: While bit 6 of register B is set, `irq` pulses high for exactly one cycle. The first pulse comes TICK_CYCLES cycles after the write edge that set the bit, and later pulses follow every TICK_CYCLES cycles.
- R7: Clearing bit 6 of B stops the pulses. Writing B with bit 6 set while the tick is already running does not restart the interval.
- R8: Reads of registers C (0x0C) and D (0x0D) return 0x00. Data writes to them set `err`.
- R9: A write of 0x26 to register A is accepted, which also clears bit 7. Any other value sets `err` and leaves A unchanged.
- R10: The calendar bytes are preset at reset as follows:
  - byte 0: seconds; byte 2: minutes; byte 4: hours; byte 7: day of month.
  - byte 6: weekday, as PRESET_WDAY0 + 1, so 1 means Sunday.
  - byte 8: month, as PRESET_MON0 + 1, in the range 1 to 12.
  - byte 9: year. With YEAR_BCD set it is two BCD digits of PRESET_YEAR modulo 100; otherwise it is PRESET_YEAR itself.
  - bytes 1, 3 and 5: zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_we | input | 1 | Strobe: load `wdata` into the index port |
| dat_we | input | 1 | Strobe: write `wdata` to the selected register |
| dat_re | input | 1 | Strobe: read the selected register |
| wdata | input | 8 | Write byte for the index and data strobes |
| rdata | output | 8 | Read result, registered one cycle after `dat_re` |
| err | output | 1 | One-cycle pulse for a refused access |
| irq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
The assertions assume that at most one of the three strobes is active in any cycle. They also assume TICK_CYCLES is at least 2, so that an expiry cycle can never be followed by another expiry. The bench drives each access as a single-cycle strobe from a task that returns only after the strobe has been sampled, so strobes never overlap. The tick checks rely on cycle stamps of each `irq` pulse measured against the cycle of the enabling write. The no-restart rewrite of register B is placed in the middle of an interval, so a restarted count would shift every later stamp.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int IDX_W      = 4;
    localparam int BYTE_W     = 8;
    localparam int IDX_A      = 10;
    localparam int IDX_B      = 11;
    localparam int IDX_C      = 12;
    localparam int IDX_D      = 13;
    localparam int IDX_MAX    = IDX_D;
    localparam int CAL_BYTES  = IDX_A;

    localparam int UIP_BIT    = 7;
    localparam int PIE_BIT    = 6;
    localparam int SQWE_BIT   = 3;
    localparam logic [7:0] A_RESET     = 8'h26;
    localparam logic [7:0] B_RESET     = 8'h46;
    localparam logic [7:0] B_FREE_MASK = 8'h48;
    localparam logic [7:0] B_FIXED     = 8'h06;

    typedef enum logic [1:0] {
        TM_OFF    = 2'd0,
        TM_ARMED  = 2'd1,
        TM_EXPIRE = 2'd2
    } tick_state_t;

    typedef enum logic [1:0] {
        RK_CAL = 2'd0,
        RK_A   = 2'd1,
        RK_B   = 2'd2,
        RK_CD  = 2'd3
    } reg_kind_t;

    function automatic reg_kind_t decode_kind(input logic [IDX_W-1:0] idx);
        if (int'(idx) < IDX_A)       return RK_CAL;
        else if (int'(idx) == IDX_A) return RK_A;
        else if (int'(idx) == IDX_B) return RK_B;
        else                         return RK_CD;
    endfunction

    function automatic logic [7:0] to_bcd2(input int value);
        int v;
        v = value % 100;
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [7:0] cal_preset(input int pos, input int sec, input int mins,
                                               input int hour, input int wday0, input int mday,
                                               input int mon0, input int year, input bit ybcd);
        case (pos)
            0:       return 8'(sec);
            2:       return 8'(mins);
            4:       return 8'(hour);
            6:       return 8'(wday0 + 1);
            7:       return 8'(mday);
            8:       return 8'(mon0 + 1);
            9:       return ybcd ? to_bcd2(year) : 8'(year);
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/rtc_calendar_bank.sv
module rtc_calendar_bank
    import rtc_pkg::*;
#(
    parameter int PRESET_SEC   = 0,
    parameter int PRESET_MIN   = 0,
    parameter int PRESET_HOUR  = 0,
    parameter int PRESET_WDAY0 = 0,
    parameter int PRESET_MDAY  = 1,
    parameter int PRESET_MON0  = 0,
    parameter int PRESET_YEAR  = 100,
    parameter bit YEAR_BCD     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rd_byte
);
    logic [BYTE_W-1:0] bytes_q [CAL_BYTES];

    for (genvar g = 0; g < CAL_BYTES; g++) begin : g_byte
        localparam logic [BYTE_W-1:0] PRESET = cal_preset(g, PRESET_SEC, PRESET_MIN,
            PRESET_HOUR, PRESET_WDAY0, PRESET_MDAY, PRESET_MON0, PRESET_YEAR, YEAR_BCD);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bytes_q[g] <= PRESET;
            else if (wr_en && (int'(idx) == g))
                bytes_q[g] <= wdata;
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < CAL_BYTES; i++)
            if (int'(idx) == i) rd_byte = bytes_q[i];
    end

    // R2: a write lands in the addressed byte
    p_cal_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_byte == $past(wdata) || $past(idx) != idx);
endmodule

// File: rtl/rtc_status_regs.sv
module rtc_status_regs
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic              b_we,
    input  logic              a_re,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] reg_a,
    output logic [BYTE_W-1:0] reg_b,
    output logic              bad_a,
    output logic              bad_b
);
    assign bad_a = (wdata != A_RESET);
    assign bad_b = ((wdata & ~B_FREE_MASK) != B_FIXED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_a <= A_RESET;
        end else if (a_we && !bad_a) begin
            reg_a <= wdata;
        end else if (a_re) begin
            reg_a[UIP_BIT] <= ~reg_a[UIP_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            reg_b <= B_RESET;
        else if (b_we && !bad_b)
            reg_b <= wdata;
    end

    // R4: every read of A inverts the update-in-progress flag
    p_uip_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_re && !a_we) |=> reg_a[UIP_BIT] != $past(reg_a[UIP_BIT]));
    // R5: binary and 24-hour modes never leave register B
    p_b_modes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_b & ~B_FREE_MASK) == B_FIXED);
    // R5: a refused write keeps B
    p_b_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_we && bad_b) |=> $stable(reg_b));
    // R9: the divider and rate field stays fixed
    p_a_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_a[6:0] == A_RESET[6:0]);
endmodule

// File: rtl/rtc_tick_fsm.sv
module rtc_tick_fsm
    import rtc_pkg::*;
#(
    parameter int TICK_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_nx,
    output logic irq
);
    localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_CYCLES - 1);

    tick_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TM_OFF: begin
                if (enable_nx) begin
                    state_d = TM_ARMED;
                    cnt_d   = '0;
                end
            end
            TM_ARMED: begin
                if (!enable_nx) begin
                    state_d = TM_OFF;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = TM_EXPIRE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            TM_EXPIRE: begin
                if (!enable_nx) begin
                    state_d = TM_OFF;
                    cnt_d   = '0;
                end else begin
                    state_d = TM_ARMED;
                    cnt_d   = CNT_W'(1);
                end
            end
            default: begin
                state_d = TM_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TM_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        irq = (state_q == TM_EXPIRE);
    end

    // R6: the interrupt is a single-cycle pulse
    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R6: the interval counter stays inside its window
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < TICK_CYCLES);
    // R7: a cleared enable silences the next cycle
    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_nx |=> !irq);
endmodule

// File: rtl/rtc_cmos_regfile.sv
module rtc_cmos_regfile
    import rtc_pkg::*;
#(
    parameter int TICK_CYCLES  = 1000,
    parameter int PRESET_SEC   = 0,
    parameter int PRESET_MIN   = 0,
    parameter int PRESET_HOUR  = 0,
    parameter int PRESET_WDAY0 = 0,
    parameter int PRESET_MDAY  = 1,
    parameter int PRESET_MON0  = 0,
    parameter int PRESET_YEAR  = 100,
    parameter bit YEAR_BCD     = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_we,
    input  logic       dat_we,
    input  logic       dat_re,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       err,
    output logic       irq
);
    logic [IDX_W-1:0] idx_q;
    reg_kind_t        kind;
    logic [7:0]       cal_byte, reg_a, reg_b;
    logic             bad_a, bad_b, bad_idx, refuse, enable_nx;

    assign kind    = decode_kind(idx_q);
    assign bad_idx = (int'(wdata) > IDX_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= '0;
        else if (idx_we && !bad_idx)
            idx_q <= wdata[IDX_W-1:0];
    end

    rtc_calendar_bank #(
        .PRESET_SEC(PRESET_SEC), .PRESET_MIN(PRESET_MIN), .PRESET_HOUR(PRESET_HOUR),
        .PRESET_WDAY0(PRESET_WDAY0), .PRESET_MDAY(PRESET_MDAY), .PRESET_MON0(PRESET_MON0),
        .PRESET_YEAR(PRESET_YEAR), .YEAR_BCD(YEAR_BCD)
    ) u_cal (
        .clk(clk), .rst_n(rst_n),
        .wr_en(dat_we && kind == RK_CAL),
        .idx(idx_q), .wdata(wdata), .rd_byte(cal_byte)
    );

    rtc_status_regs u_stat (
        .clk(clk), .rst_n(rst_n),
        .a_we(dat_we && kind == RK_A),
        .b_we(dat_we && kind == RK_B),
        .a_re(dat_re && kind == RK_A),
        .wdata(wdata), .reg_a(reg_a), .reg_b(reg_b),
        .bad_a(bad_a), .bad_b(bad_b)
    );

    always_comb begin
        enable_nx = reg_b[PIE_BIT];
        if (dat_we && kind == RK_B && !bad_b)
            enable_nx = wdata[PIE_BIT];
    end

    rtc_tick_fsm #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk(clk), .rst_n(rst_n), .enable_nx(enable_nx), .irq(irq)
    );

    always_comb begin
        refuse = idx_we && bad_idx;
        if (dat_we) begin
            unique case (kind)
                RK_CAL:  refuse = 1'b0;
                RK_A:    refuse = bad_a;
                RK_B:    refuse = bad_b;
                RK_CD:   refuse = 1'b1;
                default: refuse = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            err <= refuse;
            if (dat_re) begin
                unique case (kind)
                    RK_CAL:  rdata <= cal_byte;
                    RK_A:    rdata <= reg_a ^ (8'h1 << UIP_BIT);
                    RK_B:    rdata <= reg_b;
                    RK_CD:   rdata <= 8'h00;
                    default: rdata <= 8'h00;
                endcase
            end
        end
    end

    // input assumption: one strobe per cycle
    p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({idx_we, dat_we, dat_re}));
    // R1: the index stays in range
    p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(idx_q) <= IDX_MAX);
    // R1: out-of-range index is refused and kept
    p_bad_idx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_we && int'(wdata) > IDX_MAX) |=> ($stable(idx_q) && err));
    // R8: C and D read zero
    p_cd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_re && int'(idx_q) >= IDX_C) |=> rdata == 8'h00);
    // R8: writes to C and D are flagged
    p_cd_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && int'(idx_q) >= IDX_C) |=> err);
    // R2: rdata only moves after a read strobe
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_re |=> $stable(rdata));
endmodule

// File: tb/sim_rtc_cmos_regfile.sv
`timescale 1ns/1ps
module sim_rtc_cmos_regfile;
    localparam int T = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_we = 1'b0, dat_we = 1'b0, dat_re = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       err, irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic re_seen = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    int         irq_log[$];
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_cmos_regfile #(
        .TICK_CYCLES(T), .PRESET_SEC(30), .PRESET_MIN(45), .PRESET_HOUR(13),
        .PRESET_WDAY0(3), .PRESET_MDAY(15), .PRESET_MON0(5), .PRESET_YEAR(124),
        .YEAR_BCD(1'b1)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we), .dat_re(dat_re),
        .wdata(wdata), .rdata(rdata), .err(err), .irq(irq)
    );

    always @(posedge clk) begin
        re_seen <= dat_re;
        if (rst_n && irq) irq_log.push_back(cyc);
        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: compare each read result against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (re_seen) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "scoreboard underflow", 0, 0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(rdata === e, t, rdata, e);
                end
            end
        end
    end

    task automatic set_idx(input logic [7:0] v, input bit exp_err, input string tag);
        idx_we = 1'b1; wdata = v;
        @(negedge clk);
        idx_we = 1'b0;
        check(err === exp_err, tag, err, exp_err);
    endtask

    task automatic wr(input logic [7:0] v, input bit exp_err, input string tag);
        dat_we = 1'b1; wdata = v;
        @(negedge clk);
        dat_we = 1'b0;
        check(err === exp_err, tag, err, exp_err);
    endtask

    task automatic rd(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        dat_re = 1'b1;
        @(negedge clk);
        dat_re = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5.0);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int e0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(rdata === 8'h00 && err === 1'b0 && irq === 1'b0, "R3 reset outputs",
              {rdata, err, irq}, 0);

        // stop the tick that runs from reset
        set_idx(8'h0B, 1'b0, "R1 select B");
        wr(8'h06, 1'b0, "R5 clear enable accepted");
        rd(8'h06, "R5 B after clearing enable");

        // calendar presets
        rd(8'h06, "R5 B second read");
        set_idx(8'h00, 1'b0, "R1 select 0"); rd(8'd30, "R10 seconds preset");
        set_idx(8'h01, 1'b0, "R1 select 1"); rd(8'h00, "R10 byte 1 zero");
        set_idx(8'h02, 1'b0, "R1 select 2"); rd(8'd45, "R10 minutes preset");
        set_idx(8'h04, 1'b0, "R1 select 4"); rd(8'd13, "R10 hours preset");
        set_idx(8'h06, 1'b0, "R1 select 6"); rd(8'd4,  "R10 weekday Sunday=1");
        set_idx(8'h07, 1'b0, "R1 select 7"); rd(8'd15, "R10 day of month");
        set_idx(8'h08, 1'b0, "R1 select 8"); rd(8'd6,  "R10 month one-based");
        set_idx(8'h09, 1'b0, "R1 select 9"); rd(8'h24, "R10 BCD year");

        // register A alternation
        set_idx(8'h0A, 1'b0, "R1 select A");
        rd(8'hA6, "R4 first A read");
        rd(8'h26, "R4 second A read");
        rd(8'hA6, "R4 third A read");
        // A now holds 0xA6 internally
        wr(8'h27, 1'b1, "R9 bad A write flagged");
        rd(8'h26, "R9 A unchanged after refusal");
        wr(8'h26, 1'b0, "R9 good A write accepted");
        rd(8'hA6, "R9 A write cleared flag");

        // C and D
        set_idx(8'h0C, 1'b0, "R1 select C");
        rd(8'h00, "R8 C reads zero");
        wr(8'hFF, 1'b1, "R8 C write flagged");
        rd(8'h00, "R8 C still zero");
        set_idx(8'h0D, 1'b0, "R1 select D");
        rd(8'h00, "R8 D reads zero");
        wr(8'h12, 1'b1, "R8 D write flagged");

        // calendar write and out-of-range index
        set_idx(8'h03, 1'b0, "R1 select 3");
        wr(8'h5A, 1'b0, "R2 calendar write");
        set_idx(8'h0E, 1'b1, "R1 index 0x0E refused");
        rd(8'h5A, "R1 index kept after refusal");
        set_idx(8'hFF, 1'b1, "R1 index 0xFF refused");
        wr(8'hC3, 1'b0, "R2 overwrite kept index");
        rd(8'hC3, "R2 calendar readback");
        set_idx(8'h00, 1'b0, "R1 select 0 again");
        wr(8'h00, 1'b0, "R2 write zero");
        rd(8'h00, "R2 zero readback");
        set_idx(8'h09, 1'b0, "R1 select 9 again");
        rd(8'h24, "R2 neighbour untouched");

        // register B rules
        set_idx(8'h0B, 1'b0, "R1 select B again");
        wr(8'h40, 1'b1, "R5 binary bit cleared flagged");
        rd(8'h06, "R5 B unchanged");
        wr(8'h0E, 1'b0, "R5 square-wave enable accepted");
        rd(8'h0E, "R5 B holds square-wave bit");
        wr(8'h0C, 1'b1, "R5 24-hour cleared flagged");
        rd(8'h0E, "R5 B unchanged again");

        // no pulses while disabled
        irq_log.delete();
        repeat (3 * T) @(negedge clk);
        check(irq_log.size() == 0, "R7 quiet while disabled", irq_log.size(), 0);

        // start the tick
        wr(8'h46, 1'b0, "R6 enable accepted");
        e0 = cyc;
        repeat (T + 5) @(negedge clk);
        wr(8'h4E, 1'b0, "R7 rewrite while running");
        repeat (2 * T + 3) @(negedge clk);
        check(irq_log.size() == 3, "R6 pulse count", irq_log.size(), 3);
        for (int k = 0; k < 3; k++) begin
            if (k < irq_log.size())
                check(irq_log[k] == e0 + (k + 1) * T, "R7 R6 pulse timing",
                      irq_log[k] - e0, (k + 1) * T);
        end
        wr(8'h06, 1'b0, "R7 disable accepted");
        repeat (3 * T) @(negedge clk);
        check(irq_log.size() == 3, "R7 pulses stop", irq_log.size(), 3);
        rd(8'h06, "R7 B after disable");
        @(negedge clk);
        finish_run();
    end
endmodule